// File: doc/BRIEF.md
# Keyboard Controller Host Front End

This block is the side of a legacy keyboard controller that the host processor sees. It decodes byte-wide I/O reads and writes to a data port at 60h and a command/status port at 64h. It keeps the controller dormant through a fixed power-up hold and until a mandatory self-test handshake has taken place. Once it is running, it accepts scancode bytes that a separate serial receiver has already assembled. It drives a one-cycle fast warm-reset request and a level that gates address line 20. It also owns a small bank of general-purpose pins, each backed by an internal register bit.

Integration works as follows. Bus strobes are single-cycle pulses in the system clock domain. Read data is registered and is valid in the cycle after the read strobe. The power-good level and the keyboard clock arrive asynchronously and are synchronised inside the block. A keylock switch input stops keyboard bytes from reaching the output buffer.

Top module: `kbc_host_front`

## Requirements
- R1: While `rst` is high or power-good is low, `a20_en` is 1, `warm_rst_req` is 0 and `gpio_oe` is 0, and any read returns FFh.
- R2: After power-good rises, every access is ignored until 120 rising keyboard-clock edges have been counted (`HOLD_CLKS`). A self-test command written during the hold has no effect.
- R3: Once the hold ends, every access is ignored until the value AAh is written to port 64h. While this lock is in force, reads return FFh, FEh writes produce no reset pulse, and writes have no effect on `a20_en`.
- R4: After the AAh write to port 64h, the next read of either port returns 55h.
- R5: Outside the pass-code read, a read of port 64h returns a status byte. Bit 0 is set when the output buffer is full. Bit 1 is set in the cycle right after an accepted host write. Bits 7..2 are 0.
- R6: A write of FEh to port 64h makes `warm_rst_req` high for exactly one cycle, the cycle after the write.
- R7: A write of D1h to port 64h, followed by a write to port 60h, sets `a20_en` to bit 1 of the data byte. A write to port 60h with no such prefix leaves `a20_en` unchanged.
- R8: When `keylock` is low and the output buffer is empty, a keyboard byte (`kb_valid`) is loaded into the output buffer. A read of port 60h returns that byte and empties the buffer.
- R9: While `keylock` is high, keyboard bytes are dropped and the output buffer stays empty.
- R10: A write of 90h to port 64h, followed by a data write, loads `gpio_oe` from data bits 3..0. A write of 91h followed by a data write loads the register bits from data bits 3..0, and every bit whose `gpio_oe` is 1 drives its value on `gpio_out`.
- R11: A register bit whose `gpio_oe` is 0 follows its `gpio_in` pin. A write of 92h to port 64h puts {0000b, register bits} into the output buffer.
- R12: When power-good falls during operation, the block returns to the state of R1. It must then go through the hold and the self-test handshake again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_ok | input | 1 | Power-good level, asynchronous |
| kb_clk | input | 1 | Keyboard clock, asynchronous, used to time the hold |
| keylock | input | 1 | High blocks keyboard bytes |
| kb_valid | input | 1 | One-cycle strobe for a received keyboard byte |
| kb_byte | input | 8 | Received keyboard byte |
| io_addr | input | ADDR_W | I/O address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid the cycle after `io_rd` |
| warm_rst_req | output | 1 | One-cycle fast warm-reset request |
| a20_en | output | 1 | Address-line-20 gate level |
| gpio_in | input | NGPIO | General-purpose pin inputs |
| gpio_out | output | NGPIO | General-purpose register values |
| gpio_oe | output | NGPIO | General-purpose output enables |

## Verification
A lock flag that fails to clear on a power-good drop shows up at the ports straight away. The next read returns 55h or a status byte instead of FFh, or an FEh write produces a reset pulse. A hold counter that ends early or late shows up as a self-test write that is accepted, or refused, around the 120th keyboard edge. A stale pending-command state shows up as a later plain data write that changes `a20_en` or the GPIO enables in the very next cycle. A lost output-buffer flag shows up in the following status read as a wrong bit 0.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam logic [7:0] PORT_DATA  = 8'h60;
  localparam logic [7:0] PORT_CMD   = 8'h64;
  localparam logic [7:0] CMD_SELFTEST = 8'hAA;
  localparam logic [7:0] CMD_PULSE_RST = 8'hFE;
  localparam logic [7:0] CMD_SET_A20 = 8'hD1;
  localparam logic [7:0] CMD_GPIO_DIR = 8'h90;
  localparam logic [7:0] CMD_GPIO_VAL = 8'h91;
  localparam logic [7:0] CMD_GPIO_RD  = 8'h92;
  localparam logic [7:0] PASS_CODE  = 8'h55;
  localparam logic [7:0] IDLE_READ  = 8'hFF;

  typedef enum logic [1:0] {
    PEND_NONE,
    PEND_A20,
    PEND_DIR,
    PEND_VAL
  } pend_t;
endpackage

// File: rtl/kbc_hold_timer.sv
module kbc_hold_timer #(
  parameter int HOLD_CLKS = 120,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_ok,
  input  logic kb_clk,
  output logic ready
);
  localparam int CW = $clog2(HOLD_CLKS + 1);

  logic [SYNC_STAGES-1:0] pwr_sync;
  logic [SYNC_STAGES:0]   kbc_sync;
  logic [CW-1:0]          edge_cnt;
  logic                   kb_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_sync <= '0;
      kbc_sync <= '0;
    end else begin
      pwr_sync <= {pwr_sync[SYNC_STAGES-2:0], pwr_ok};
      kbc_sync <= {kbc_sync[SYNC_STAGES-1:0], kb_clk};
    end
  end

  assign kb_rise = kbc_sync[SYNC_STAGES-1] & ~kbc_sync[SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (rst || !pwr_sync[SYNC_STAGES-1]) begin
      edge_cnt <= '0;
      ready    <= 1'b0;
    end else begin
      if (kb_rise && edge_cnt != CW'(HOLD_CLKS))
        edge_cnt <= edge_cnt + 1'b1;
      ready <= (edge_cnt == CW'(HOLD_CLKS));
    end
  end
endmodule

// File: rtl/kbc_gpio_bank.sv
module kbc_gpio_bank #(
  parameter int NGPIO = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             ld_dir,
  input  logic             ld_val,
  input  logic [NGPIO-1:0] wdata,
  input  logic [NGPIO-1:0] pin_in,
  output logic [NGPIO-1:0] val_o,
  output logic [NGPIO-1:0] oe_o
);
  for (genvar g = 0; g < NGPIO; g++) begin : g_bit
    logic [SYNC_STAGES-1:0] in_sync;
    logic                   oe_r;
    logic                   val_r;

    always_ff @(posedge clk) begin
      if (clr) begin
        in_sync <= '0;
        oe_r    <= 1'b0;
        val_r   <= 1'b0;
      end else begin
        in_sync <= {in_sync[SYNC_STAGES-2:0], pin_in[g]};
        if (ld_dir)
          oe_r <= wdata[g];
        if (ld_val)
          val_r <= wdata[g];
        else if (!oe_r)
          val_r <= in_sync[SYNC_STAGES-1];
      end
    end

    assign val_o[g] = val_r;
    assign oe_o[g]  = oe_r;
  end
endmodule

// File: rtl/kbc_cmd_engine.sv
module kbc_cmd_engine
  import kbc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NGPIO  = 4
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              kb_valid,
  input  logic [7:0]        kb_byte,
  input  logic              keylock,
  input  logic [NGPIO-1:0]  gpio_val,
  output logic [7:0]        io_rdata,
  output logic              warm_rst_req,
  output logic              a20_en,
  output logic              ld_dir,
  output logic              ld_val,
  output logic              unlocked
);
  logic  hit_data, hit_cmd;
  logic  st_pend, obf, ibf;
  logic [7:0] outbuf;
  pend_t pend;
  logic  wr_data_ok;

  assign hit_data = (io_addr == ADDR_W'(PORT_DATA));
  assign hit_cmd  = (io_addr == ADDR_W'(PORT_CMD));
  assign wr_data_ok = unlocked && io_wr && hit_data;
  assign ld_dir = wr_data_ok && (pend == PEND_DIR);
  assign ld_val = wr_data_ok && (pend == PEND_VAL);

  always_ff @(posedge clk) begin
    if (clr) begin
      unlocked     <= 1'b0;
      st_pend      <= 1'b0;
      obf          <= 1'b0;
      ibf          <= 1'b0;
      outbuf       <= '0;
      pend         <= PEND_NONE;
      a20_en       <= 1'b1;
      warm_rst_req <= 1'b0;
      io_rdata     <= IDLE_READ;
    end else if (!unlocked) begin
      warm_rst_req <= 1'b0;
      ibf          <= 1'b0;
      if (io_rd)
        io_rdata <= IDLE_READ;
      if (io_wr && hit_cmd && io_wdata == CMD_SELFTEST) begin
        unlocked <= 1'b1;
        st_pend  <= 1'b1;
      end
    end else begin
      warm_rst_req <= 1'b0;
      ibf          <= io_wr && (hit_cmd || hit_data);

      if (kb_valid && !keylock && !obf) begin
        outbuf <= kb_byte;
        obf    <= 1'b1;
      end

      if (io_rd) begin
        if (st_pend && (hit_cmd || hit_data)) begin
          io_rdata <= PASS_CODE;
          st_pend  <= 1'b0;
        end else if (hit_cmd) begin
          io_rdata <= {6'b0, ibf, obf};
        end else if (hit_data) begin
          io_rdata <= outbuf;
          obf      <= 1'b0;
        end else begin
          io_rdata <= IDLE_READ;
        end
      end

      if (io_wr && hit_cmd) begin
        pend <= PEND_NONE;
        case (io_wdata)
          CMD_SELFTEST:  st_pend <= 1'b1;
          CMD_PULSE_RST: warm_rst_req <= 1'b1;
          CMD_SET_A20:   pend <= PEND_A20;
          CMD_GPIO_DIR:  pend <= PEND_DIR;
          CMD_GPIO_VAL:  pend <= PEND_VAL;
          CMD_GPIO_RD: begin
            outbuf <= {{(8-NGPIO){1'b0}}, gpio_val};
            obf    <= 1'b1;
          end
          default: ;
        endcase
      end else if (wr_data_ok) begin
        pend <= PEND_NONE;
        if (pend == PEND_A20)
          a20_en <= io_wdata[1];
      end
    end
  end
endmodule

// File: rtl/kbc_host_front.sv
module kbc_host_front #(
  parameter int ADDR_W    = 16,
  parameter int NGPIO     = 4,
  parameter int HOLD_CLKS = 120
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_ok,
  input  logic              kb_clk,
  input  logic              keylock,
  input  logic              kb_valid,
  input  logic [7:0]        kb_byte,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              warm_rst_req,
  output logic              a20_en,
  input  logic [NGPIO-1:0]  gpio_in,
  output logic [NGPIO-1:0]  gpio_out,
  output logic [NGPIO-1:0]  gpio_oe
);
  logic host_ready;
  logic core_clr;
  logic unlocked;
  logic ld_dir, ld_val;
  logic [NGPIO-1:0] gpio_val;

  assign core_clr = rst || !host_ready;

  kbc_hold_timer #(.HOLD_CLKS(HOLD_CLKS)) u_hold (
    .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .kb_clk(kb_clk), .ready(host_ready)
  );

  kbc_cmd_engine #(.ADDR_W(ADDR_W), .NGPIO(NGPIO)) u_eng (
    .clk(clk), .clr(core_clr), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_wdata(io_wdata), .kb_valid(kb_valid), .kb_byte(kb_byte), .keylock(keylock),
    .gpio_val(gpio_val), .io_rdata(io_rdata), .warm_rst_req(warm_rst_req),
    .a20_en(a20_en), .ld_dir(ld_dir), .ld_val(ld_val), .unlocked(unlocked)
  );

  kbc_gpio_bank #(.NGPIO(NGPIO)) u_gpio (
    .clk(clk), .clr(core_clr), .ld_dir(ld_dir), .ld_val(ld_val),
    .wdata(io_wdata[NGPIO-1:0]), .pin_in(gpio_in), .val_o(gpio_val), .oe_o(gpio_oe)
  );

  assign gpio_out = gpio_val;
endmodule

// File: rtl/kbc_host_front_chk.sv
module kbc_host_front_chk #(
  parameter int NGPIO = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             io_rd,
  input logic [7:0]       io_rdata,
  input logic             warm_rst_req,
  input logic             a20_en,
  input logic [NGPIO-1:0] gpio_oe,
  input logic             ready,
  input logic             unlocked
);
  assert_pulse_once_R6: assert property (@(posedge clk) disable iff (rst)
    warm_rst_req |=> !warm_rst_req);

  assert_a20_default_R1: assert property (@(posedge clk) disable iff (rst)
    !ready |=> a20_en);

  assert_oe_default_R12: assert property (@(posedge clk) disable iff (rst)
    !ready |=> (gpio_oe == '0));

  assert_hold_blocks_R2: assert property (@(posedge clk) disable iff (rst)
    !ready |=> !unlocked);

  assert_locked_read_R3: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !unlocked) |=> (io_rdata == 8'hFF));

  assert_locked_no_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    !unlocked |=> !warm_rst_req);
endmodule

bind kbc_host_front kbc_host_front_chk #(.NGPIO(NGPIO)) u_chk (
  .clk(clk), .rst(rst), .io_rd(io_rd), .io_rdata(io_rdata),
  .warm_rst_req(warm_rst_req), .a20_en(a20_en), .gpio_oe(gpio_oe),
  .ready(host_ready), .unlocked(unlocked)
);

// File: tb/sim_kbc_host_front.sv
`timescale 1ns/1ps
module sim_kbc_host_front;
  localparam int AW = 16;
  localparam int NG = 4;

  logic clk = 0, rst = 1, pwr_ok = 0, kb_clk = 0, keylock = 0, kb_valid = 0;
  logic [7:0] kb_byte = '0, io_wdata = '0, io_rdata;
  logic [AW-1:0] io_addr = '0;
  logic io_wr = 0, io_rd = 0, warm_rst_req, a20_en;
  logic [NG-1:0] gpio_in = '0, gpio_out, gpio_oe;

  int total = 0, bad = 0, pulses = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always #20 kb_clk = ~kb_clk;

  kbc_host_front #(.ADDR_W(AW), .NGPIO(NG), .HOLD_CLKS(120)) u0 (
    .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .kb_clk(kb_clk), .keylock(keylock),
    .kb_valid(kb_valid), .kb_byte(kb_byte), .io_addr(io_addr), .io_wr(io_wr),
    .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .warm_rst_req(warm_rst_req), .a20_en(a20_en), .gpio_in(gpio_in),
    .gpio_out(gpio_out), .gpio_oe(gpio_oe)
  );

  always @(posedge clk) if (!rst && warm_rst_req) pulses <= pulses + 1;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    io_addr = AW'(a); io_wdata = d; io_wr = 1;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    io_addr = AW'(a); io_rd = 1;
    @(negedge clk); io_rd = 0; d = io_rdata;
  endtask

  task automatic kbpush(input logic [7:0] b);
    kb_byte = b; kb_valid = 1;
    @(negedge clk); kb_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    idle(4);
    chk("R1 a20", 8'(a20_en), 8'h01);
    chk("R1 pulse", 8'(warm_rst_req), 8'h00);
    chk("R1 oe", 8'(gpio_oe), 8'h00);
    rd(8'h64, d); chk("R1 read", d, 8'hFF);
  endtask

  task automatic t_hold;
    logic [7:0] d;
    rst = 0; pwr_ok = 1;
    idle(10);
    wr(8'h64, 8'hAA);
    rd(8'h64, d); chk("R2 read during hold", d, 8'hFF);
    idle(1200);
    rd(8'h64, d); chk("R2 early selftest dropped", d, 8'hFF);
  endtask

  task automatic t_locked;
    logic [7:0] d;
    wr(8'h64, 8'hFE); idle(3);
    chk("R3 no pulse when locked", 8'(pulses), 8'h00);
    wr(8'h64, 8'hD1); wr(8'h60, 8'h00); idle(1);
    chk("R3 a20 unchanged", 8'(a20_en), 8'h01);
    rd(8'h60, d); chk("R3 data read", d, 8'hFF);
  endtask

  task automatic t_selftest;
    logic [7:0] d;
    wr(8'h64, 8'hAA);
    rd(8'h64, d); chk("R4 pass code", d, 8'h55);
    rd(8'h64, d); chk("R5 idle status", d, 8'h00);
  endtask

  task automatic t_status;
    logic [7:0] d;
    wr(8'h60, 8'h12);
    rd(8'h64, d); chk("R5 ibf after write", d, 8'h02);
    rd(8'h64, d); chk("R5 ibf cleared", d, 8'h00);
  endtask

  task automatic t_kb;
    logic [7:0] d;
    kbpush(8'h1C);
    rd(8'h64, d); chk("R5 obf set", d, 8'h01);
    rd(8'h60, d); chk("R8 byte", d, 8'h1C);
    rd(8'h64, d); chk("R8 obf cleared", d, 8'h00);
  endtask

  task automatic t_keylock;
    logic [7:0] d;
    keylock = 1; kbpush(8'h2A); idle(2);
    rd(8'h64, d); chk("R9 byte dropped", d, 8'h00);
    keylock = 0; kbpush(8'h33);
    rd(8'h60, d); chk("R9 accepted after unlock", d, 8'h33);
  endtask

  task automatic t_fastreset;
    int p0;
    p0 = pulses;
    wr(8'h64, 8'hFE);
    chk("R6 pulse high", 8'(warm_rst_req), 8'h01);
    @(negedge clk);
    chk("R6 pulse low", 8'(warm_rst_req), 8'h00);
    chk("R6 one pulse", 8'(pulses - p0), 8'h01);
  endtask

  task automatic t_a20;
    wr(8'h64, 8'hD1); wr(8'h60, 8'h00);
    chk("R7 a20 off", 8'(a20_en), 8'h00);
    wr(8'h64, 8'hD1); wr(8'h60, 8'h02);
    chk("R7 a20 on", 8'(a20_en), 8'h01);
    wr(8'h64, 8'hD1); wr(8'h60, 8'hFD);
    chk("R7 a20 bit1 only", 8'(a20_en), 8'h00);
    wr(8'h60, 8'h02);
    chk("R7 plain write ignored", 8'(a20_en), 8'h00);
  endtask

  task automatic t_gpio;
    logic [7:0] d;
    gpio_in = 4'b1010; idle(5);
    wr(8'h64, 8'h92);
    rd(8'h60, d); chk("R11 input capture", d, 8'h0A);
    wr(8'h64, 8'h90); wr(8'h60, 8'h03);
    chk("R10 oe", 8'(gpio_oe), 8'h03);
    wr(8'h64, 8'h91); wr(8'h60, 8'h05);
    chk("R10 driven", 8'(gpio_out & gpio_oe), 8'h01);
    idle(5);
    wr(8'h64, 8'h92);
    rd(8'h60, d); chk("R11 mixed", d, 8'h09);
  endtask

  task automatic t_powerloss;
    logic [7:0] d;
    pwr_ok = 0; idle(5);
    chk("R12 a20", 8'(a20_en), 8'h01);
    chk("R12 oe", 8'(gpio_oe), 8'h00);
    rd(8'h64, d); chk("R12 read", d, 8'hFF);
    pwr_ok = 1; idle(1100);
    rd(8'h64, d); chk("R12 relocked", d, 8'hFF);
    wr(8'h64, 8'hAA);
    rd(8'h60, d); chk("R12 selftest again", d, 8'h55);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset;
    t_hold;
    t_locked;
    t_selftest;
    t_status;
    t_kb;
    t_keylock;
    t_fastreset;
    t_a20;
    t_gpio;
    t_powerloss;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule